// File: doc/BRIEF.md
# Slotted Scrambled Response Transmitter

This block drives the load-modulation control line of a passive tag when the tag answers a reader. A response is handed over as a word of up to twelve bits, a bit count and a mode flag. The flag picks either a whitened data frame or a single-bit write acknowledge. From the moment a request is taken, the block counts a fixed turnaround gap on a shared tick strobe. During that gap it advances an external keystream generator by a fixed number of steps. It then holds each response bit on the modulate line for exactly one bit slot, and finally drops the line.

The keystream generator sits outside the block. The block reads the generator's current bit on `ks_bit_i` and asks it to advance with a one-cycle `ks_step_o` pulse. The generator must update on the same clock edge. All timing counts only cycles in which `tick_i` is high, and cycles without a tick freeze the block.

The request side is a valid/ready stream. A request transfers on a clock edge where both `req_valid_i` and `req_ready_o` are high, and its fields are captured there. `req_ready_o` is low for the whole time a response is in flight. A source may hold `req_valid_i` high while ready is low. Nothing is captured then, and the active response continues unchanged.

Top module: `rtx_slot_tx`

## Requirements
- R1: After reset, `mod_o`, `busy_o`, `done_o` and `ks_step_o` are low and `req_ready_o` is high.
- R2: A request is accepted on an edge with `req_valid_i` and `req_ready_o` both high. `busy_o` is high from the next cycle until the edge that releases modulation, and `req_ready_o` equals the inverse of `busy_o`.
- R3: In data mode (`req_ack_i` = 0), bit 0 appears on `mod_o` at the 70th tick edge after acceptance. `ks_step_o` pulses on the first 2 ticks of that gap and on no other gap tick.
- R4: Data bits go out in order from bit 0 of `req_word_i` upward, `req_len_i` bits in all (legal range 1 to 12). Each bit drives `mod_o` to the word bit XOR `ks_bit_i`, taken on the tick edge that loads it. `ks_step_o` pulses on that same tick.
- R5: In acknowledge mode (`req_ack_i` = 1), the word and the length are ignored. One bit of value 1 appears at the 758th tick edge after acceptance, not XORed with the keystream. `ks_step_o` pulses on the first 35 gap ticks and once more on the tick that loads the bit.
- R6: On the last tick of the last slot, `done_o` is high for that one cycle. At that edge, `mod_o` goes low and `busy_o` falls.
- R7: A request presented while busy is not accepted: `req_ready_o` stays low, and the frame in flight keeps its bits and timing.
- R8: Each bit holds `mod_o` for 21 ticks, and `mod_o` changes only on slot boundaries. Two equal adjacent bits keep the line steady, with no return to low between them.
- R9: Cycles with `tick_i` low leave `mod_o`, `busy_o` and every slot and gap count unchanged, and they raise neither `ks_step_o` nor `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base strobe, one per tick |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (high when idle) |
| req_ack_i | input | 1 | 1 = acknowledge mode, 0 = data mode |
| req_word_i | input | 12 | Response word, bit 0 sent first |
| req_len_i | input | 4 | Data bit count, 1 to 12 |
| ks_bit_i | input | 1 | Current keystream bit |
| ks_step_o | output | 1 | Advance the keystream on this edge |
| mod_o | output | 1 | Subcarrier modulate enable |
| busy_o | output | 1 | Response in flight |
| done_o | output | 1 | High on the final tick of a response |

## Verification
The assertions rely on three things from the environment. A data-mode request carries a length from 1 to 12. The keystream source updates `ks_bit_i` only on edges where `ks_step_o` is high. `tick_i` is a clean single-cycle strobe. The stimulus stays inside these limits. Every data request uses a legal length. The keystream model in the bench moves only on step pulses. The tick strobe comes from a counter that runs either every cycle or every third cycle. The only out-of-range value the bench sends is a zero length in acknowledge mode, where the length is a don't-care.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
  typedef enum logic [1:0] {
    RTX_IDLE = 2'd0,
    RTX_GAP  = 2'd1,
    RTX_SEND = 2'd2
  } rtx_state_e;
endpackage

// File: rtl/rtx_tick_counter.sv
module rtx_tick_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         at_limit
);
  assign at_limit = (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en)     cnt <= at_limit ? '0 : cnt + 1'b1;
  end

  // R9
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(cnt));
endmodule

// File: rtl/rtx_bit_pick.sv
module rtx_bit_pick #(
  parameter int N  = 12,
  parameter int IW = 4
) (
  input  logic [N-1:0]  word,
  input  logic [IW-1:0] idx,
  input  logic          ack,
  input  logic          ks,
  output logic          bit_o
);
  logic sel;

  always_comb begin
    sel = 1'b0;
    for (int i = 0; i < N; i++)
      if (idx == IW'(i)) sel = word[i];
  end

  // R5: acknowledge bit is a plain 1; R4: data bits are whitened
  assign bit_o = ack ? 1'b1 : (sel ^ ks);
endmodule

// File: rtl/rtx_slot_tx.sv
module rtx_slot_tx #(
  parameter int GAP_DATA   = 70,
  parameter int GAP_ACK    = 758,
  parameter int SLOT_TICKS = 21,
  parameter int MAX_BITS   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_ack_i,
  input  logic [MAX_BITS-1:0] req_word_i,
  input  logic [$clog2(MAX_BITS+1)-1:0] req_len_i,
  input  logic                ks_bit_i,
  output logic                ks_step_o,
  output logic                mod_o,
  output logic                busy_o,
  output logic                done_o
);
  import rtx_pkg::*;

  localparam int GW         = $clog2(GAP_ACK + 1);
  localparam int SW         = $clog2(SLOT_TICKS + 1);
  localparam int LW         = $clog2(MAX_BITS + 1);
  localparam int STEPS_DATA = GAP_DATA / SLOT_TICKS - 1;
  localparam int STEPS_ACK  = GAP_ACK / SLOT_TICKS - 1;

  rtx_state_e          state_q;
  logic [MAX_BITS-1:0] word_q;
  logic [LW-1:0]       nbits_q;
  logic                ack_q;
  logic [LW-1:0]       idx_q;
  logic                mod_q;

  logic          accept, in_gap, in_send;
  logic [GW-1:0] gap_cnt, gap_lim, steps_lim;
  logic          gap_last, gap_end;
  logic [SW-1:0] slot_cnt;
  logic          slot_last, slot_end;
  logic [LW-1:0] nbits_eff, next_idx;
  logic          last_bit, load, finish, tx_bit;

  assign accept  = req_valid_i && (state_q == RTX_IDLE);
  assign in_gap  = (state_q == RTX_GAP);
  assign in_send = (state_q == RTX_SEND);

  assign gap_lim   = ack_q ? GW'(GAP_ACK - 1)  : GW'(GAP_DATA - 1);
  assign steps_lim = ack_q ? GW'(STEPS_ACK)    : GW'(STEPS_DATA);

  rtx_tick_counter #(.W(GW)) u_gap (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(in_gap && tick_i),
    .limit(gap_lim), .cnt(gap_cnt), .at_limit(gap_last)
  );

  assign gap_end = in_gap && tick_i && gap_last;

  rtx_tick_counter #(.W(SW)) u_slot (
    .clk(clk), .rst_n(rst_n), .clr(gap_end), .en(in_send && tick_i),
    .limit(SW'(SLOT_TICKS - 1)), .cnt(slot_cnt), .at_limit(slot_last)
  );

  assign slot_end  = in_send && tick_i && slot_last;
  assign nbits_eff = ack_q ? LW'(1) : nbits_q;
  assign last_bit  = (idx_q == nbits_eff - LW'(1));
  assign load      = gap_end || (slot_end && !last_bit);
  assign finish    = slot_end && last_bit;
  assign next_idx  = gap_end ? '0 : idx_q + LW'(1);

  rtx_bit_pick #(.N(MAX_BITS), .IW(LW)) u_pick (
    .word(word_q), .idx(next_idx), .ack(ack_q), .ks(ks_bit_i), .bit_o(tx_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RTX_IDLE;
      word_q  <= '0;
      nbits_q <= '0;
      ack_q   <= 1'b0;
      idx_q   <= '0;
      mod_q   <= 1'b0;
    end else begin
      if (accept) begin
        state_q <= RTX_GAP;
        word_q  <= req_word_i;
        nbits_q <= req_len_i;
        ack_q   <= req_ack_i;
      end
      if (gap_end) state_q <= RTX_SEND;
      if (load) begin
        idx_q <= next_idx;
        mod_q <= tx_bit;
      end
      if (finish) begin
        state_q <= RTX_IDLE;
        mod_q   <= 1'b0;
      end
    end
  end

  assign ks_step_o   = load || (in_gap && tick_i && (gap_cnt < steps_lim));
  assign mod_o       = mod_q;
  assign busy_o      = (state_q != RTX_IDLE);
  assign req_ready_o = (state_q == RTX_IDLE);
  assign done_o      = finish;

  // R4
  len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_ack_i) |-> (req_len_i != '0 && req_len_i <= LW'(MAX_BITS)));
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> busy_o);
  // R6
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !mod_o));
  // R7
  busy_holds_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req_valid_i) |=> ($stable(word_q) && $stable(nbits_q) && $stable(ack_q)));
  // R9
  no_tick_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && busy_o) |=> ($stable(mod_o) && $stable(busy_o)));
  // R3
  step_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_step_o |-> (tick_i && busy_o));
endmodule

// File: tb/sim_rtx_slot_tx.sv
`timescale 1ns/1ps
module sim_rtx_slot_tx;
  localparam int SLOT = 21;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic req_valid = 1'b0, req_ack = 1'b0;
  logic [11:0] req_word = '0;
  logic [3:0]  req_len = '0;
  logic req_ready, ks_step, mod, busy, done, ks_bit;

  always #5 clk = ~clk;

  rtx_slot_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_ack_i(req_ack), .req_word_i(req_word),
    .req_len_i(req_len), .ks_bit_i(ks_bit), .ks_step_o(ks_step),
    .mod_o(mod), .busy_o(busy), .done_o(done)
  );

  int errors = 0, checks = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0t act=%0d exp=%0d", req, $time, act, expv);
    end
  endtask

  // keystream source: LFSR sequence, advances only on step pulses
  logic ks_seq [512];
  int   ks_pos = 0;
  initial begin
    logic [15:0] l = 16'hACE1;
    for (int i = 0; i < 512; i++) begin
      ks_seq[i] = l[0];
      l = {l[0] ^ l[2] ^ l[3] ^ l[5], l[15:1]};
    end
  end
  assign ks_bit = ks_seq[ks_pos];
  always @(posedge clk) if (rst_n && ks_step) ks_pos <= ks_pos + 1;

  // tick strobe
  int tick_div = 1, cyc = 0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    tick = ((cyc % tick_div) == 0);
  end

  typedef struct { logic [11:0] bits; int n; int gap; int steps; } item_t;
  item_t q[$];
  int exp_base = 0;

  task automatic send(input bit ack, input logic [11:0] word, input int len);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    it.bits = '0;
    if (ack) begin
      it.n = 1; it.gap = 758; it.steps = 35; it.bits[0] = 1'b1;
      exp_base += 36;
    end else begin
      it.n = len; it.gap = 70; it.steps = 2;
      for (int i = 0; i < len; i++) it.bits[i] = word[i] ^ ks_seq[exp_base + 2 + i];
      exp_base += 2 + len;
    end
    q.push_back(it);
    req_valid = 1'b1; req_ack = ack; req_word = word; req_len = 4'(len);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic poke_busy();
    @(negedge clk);
    while (!busy) @(negedge clk);
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_ack = 1'b0; req_word = 12'hFFF; req_len = 4'd5;
    repeat (10) @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  item_t cur;
  bit active = 0, pend = 0, ptick = 0;
  int k = 0;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int total;
      bit e_mod, e_busy, e_done, e_step;
      string lm;
      if (pend) begin
        cur = q.pop_front(); active = 1; k = 0; pend = 0;
      end else if (active && ptick) k++;
      e_mod = 0; e_busy = 0; e_done = 0; e_step = 0; lm = "R6";
      if (active) begin
        total  = cur.gap + cur.n * SLOT;
        e_busy = (k < total);
        e_done = tick && (k == total - 1);
        e_step = tick && ((k < cur.steps) ||
                 (k >= cur.gap - 1 && k < total - 1 && ((k - (cur.gap - 1)) % SLOT) == 0));
        if (k < cur.gap) lm = (cur.gap == 758) ? "R5" : "R3";
        else if (k < total) begin
          e_mod = cur.bits[(k - cur.gap) / SLOT];
          if (!ptick) lm = "R9";
          else if (((k - cur.gap) % SLOT) != 0) lm = "R8";
          else lm = (cur.gap == 758) ? "R5" : "R4";
        end
        if (k >= total) active = 0;
      end
      check(mod == e_mod, lm, mod, e_mod);
      check(busy == e_busy, "R2", busy, e_busy);
      check(done == e_done, "R6", done, e_done);
      check(ks_step == e_step, (cur.gap == 758) ? "R5" : "R3", ks_step, e_step);
      if (req_valid) check(req_ready == !e_busy, e_busy ? "R7" : "R2", req_ready, !e_busy);
      if (req_valid && req_ready) pend = 1;
    end
    ptick = tick;
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++; checks++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", wd, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(mod == 0, "R1", mod, 0);
    check(busy == 0, "R1", busy, 0);
    check(done == 0, "R1", done, 0);
    check(ks_step == 0, "R1", ks_step, 0);
    check(req_ready == 1, "R1", req_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    send(0, 12'hA5C, 12);
    send(0, 12'h001, 1);
    send(0, 12'h055, 7);
    send(1, 12'hFFF, 0);     // R5: word and length ignored
    send(0, 12'h800, 12);
    tick_div = 3;            // R9: sparse ticks
    send(0, 12'h3C3, 12);
    poke_busy();             // R7: request while busy
    send(1, 12'h000, 3);
    tick_div = 1;
    send(0, 12'hFFF, 12);    // R8: equal adjacent bits
    send(0, 12'h000, 12);
    @(negedge clk);
    while (busy || active || pend || q.size() != 0) @(negedge clk);
    repeat (30) @(negedge clk);
    check(ks_pos == exp_base, "R4", ks_pos, exp_base);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule